// File: doc/BRIEF.md
# PCI Express Configuration Space Target

This block is the configuration-space target of a PCI Express endpoint. It accepts register reads and writes of one, two or four bytes, addressed by byte offset into a 4096-byte space. Each request is answered one clock later with read data, a valid strobe and an error flag. The space holds the standard header in the first 64 bytes. A chain of three capabilities follows: power management, MSI and MSI-X. Offsets at 0x40 and above that no capability claims read as zero, and writes to them are dropped without an error.

The MSI-X capability fields define two memory windows: the vector table and the pending-bit array. The block computes both windows from the current register contents and compares a separate memory address against them on every cycle. A memory-access unit elsewhere in the endpoint can use the two hit flags to route its accesses. When the MSI-X capability offset parameter is zero, the capability is absent and the windows are switched off.

Top module: `cfg_space_resp`

## Requirements
- R1: After reset `rsp_valid`, `rsp_err` and `rsp_rdata` are zero. Offset 0x00 reads the identity parameter. The power-management control word, the MSI address and the MSI data read zero. The table-offset register (0x64) reads 0x00002000 and the PBA-offset register (0x68) reads 0x00003000.
- R2: Every capability header packs the ID into bits 7:0 and the next-capability offset into bits 15:8. The IDs are 0x01 for power management (at 0x40), 0x05 for MSI (at 0x48) and 0x11 for MSI-X (at 0x60). The chain runs 0x40 → 0x48 → 0x60 → 0x00, and byte 0x34 holds 0x40. The MSI-X header carries the table-size field (bits 10:0, value 69) in bits 26:16.
- R3: A read of N bytes (N = `req_size`) returns the addressed bytes right-aligned, with byte (offset mod 4) of the dword in bits 7:0. All bits above 8·N are zero.
- R4: A write changes only the addressed bytes of writable fields. The following keep their values: the identity dword, the capability pointer, every capability ID and next byte, the MSI-X table-size field, and MSI-X control bits 13:0. MSI-X control bits 15:14, the PM control word (0x44, bits 15:0), the MSI data (0x54, bits 15:0) and header dwords 0x04–0x3C other than 0x34 are writable.
- R5: A legal read of an offset from 0x40 up to 0xFFF that no capability claims returns zero without an error.
- R6: A legal write to such an offset raises no error and changes no readable state.
- R7: An access is illegal if the size is not 1, 2 or 4, if the offset is 4096 or more, or if a 2-byte access has an odd offset or a 4-byte access an offset that is not a multiple of 4. An illegal access raises `rsp_err` for exactly one cycle, returns zero data and changes no register.
- R8: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise.
- R9: The table window starts at the table-offset register with bits 1:0 cleared and spans (table size + 1) × 16 bytes. `tbl_hit` is high exactly when `mem_addr` lies inside this window.
- R10: The pending-bit window starts at the PBA-offset register with bits 1:0 cleared and spans ceil((table size + 1) / 64) × 8 bytes. `pba_hit` is high exactly when `mem_addr` lies inside this window.
- R11: With the MSI-X capability offset parameter set to 0, both hit flags stay low, 0x60 reads zero, and the MSI next byte is 0x00.
- R12: Bits 1:0 of the MSI address register (0x4C) always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| mem_addr | input | 32 | Memory address compared against the MSI-X windows |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Illegal access flag, with the response |
| rsp_rdata | output | 32 | Read data, right-aligned |
| tbl_hit | output | 1 | `mem_addr` lies inside the vector-table window |
| pba_hit | output | 1 | `mem_addr` lies inside the pending-bit window |

## Verification
The assertions assume `rst_n` is held low before the first clock edge. They also assume the window registers never place a window end beyond the 32-bit address range, so the 33-bit comparison cannot wrap. The stimulus keeps to this: the table and PBA offsets it writes stay below 0x10000. Each request is driven for exactly one cycle, and every size and offset, legal or illegal, is applied only while `req_valid` is high.

// File: rtl/cfg_space_pkg.sv
package cfg_space_pkg;

  localparam logic [7:0] CAPID_PM   = 8'h01;
  localparam logic [7:0] CAPID_MSI  = 8'h05;
  localparam logic [7:0] CAPID_MSIX = 8'h11;

  // capability header: ID low byte, next pointer high byte
  function automatic logic [15:0] cap_hdr(input logic [7:0] id, input logic [7:0] nxt);
    return {nxt, id};
  endfunction

  // right-aligned byte mask for an access size; zero for an illegal size
  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd1:    return 32'h0000_00FF;
      3'd2:    return 32'h0000_FFFF;
      3'd4:    return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [11:0] msix_vecs(input logic [10:0] tsize);
    return {1'b0, tsize} + 12'd1;
  endfunction

  function automatic logic [31:0] win_base(input logic [31:0] r);
    return r & ~32'h3;
  endfunction

  function automatic logic [32:0] tbl_bytes(input logic [11:0] vecs, input int vec_bytes);
    return 33'(int'(vecs) * vec_bytes);
  endfunction

  function automatic logic [32:0] pba_bytes(input logic [11:0] vecs, input int per_entry,
                                            input int entry_bytes);
    int n;
    n = int'(vecs) / per_entry;
    if ((int'(vecs) % per_entry) != 0) n = n + 1;
    return 33'(n * entry_bytes);
  endfunction

endpackage

// File: rtl/cfg_access_dec.sv
module cfg_access_dec
  import cfg_space_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CFG_BYTES = 4096,
  parameter int DEV_BASE  = 64,
  localparam int OFF_W    = $clog2(CFG_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  output logic              legal,
  output logic              in_dev,
  output logic [OFF_W-1:0]  dw_off,
  output logic [4:0]        lane_sh,
  output logic [31:0]       narrow_mask,
  output logic [31:0]       lane_mask
);

  logic in_range;
  logic aligned;

  always_comb begin
    in_range = (addr < ADDR_W'(CFG_BYTES));
    case (size)
      3'd1:    aligned = 1'b1;
      3'd2:    aligned = (addr[0] == 1'b0);
      3'd4:    aligned = (addr[1:0] == 2'b00);
      default: aligned = 1'b0;
    endcase
    legal       = in_range && aligned;
    dw_off      = {addr[OFF_W-1:2], 2'b00};
    in_dev      = (int'(addr[OFF_W-1:0]) >= DEV_BASE);
    lane_sh     = {addr[1:0], 3'b000};
    narrow_mask = size_mask(size);
    lane_mask   = narrow_mask << lane_sh;
  end

endmodule

// File: rtl/cfg_msix_win.sv
module cfg_msix_win
  import cfg_space_pkg::*;
#(
  parameter bit ENABLE        = 1'b1,
  parameter int VEC_BYTES     = 16,
  parameter int PBA_PER_ENTRY = 64,
  parameter int PBA_ENTRY_B   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [10:0] tbl_size,
  input  logic [31:0] tbl_reg,
  input  logic [31:0] pba_reg,
  input  logic [31:0] mem_addr,
  output logic        tbl_hit,
  output logic        pba_hit
);

  generate
    if (ENABLE) begin : g_on
      logic [11:0] vecs;
      logic [32:0] tbl_lo, tbl_hi, pba_lo, pba_hi, probe;

      always_comb begin
        vecs   = msix_vecs(tbl_size);
        tbl_lo = {1'b0, win_base(tbl_reg)};
        tbl_hi = tbl_lo + tbl_bytes(vecs, VEC_BYTES);
        pba_lo = {1'b0, win_base(pba_reg)};
        pba_hi = pba_lo + pba_bytes(vecs, PBA_PER_ENTRY, PBA_ENTRY_B);
        probe  = {1'b0, mem_addr};
      end

      assign tbl_hit = (probe >= tbl_lo) && (probe < tbl_hi);
      assign pba_hit = (probe >= pba_lo) && (probe < pba_hi);

      // hit must never report an address below the cleared register base
      p_tbl_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_hit |-> (mem_addr >= (tbl_reg & ~32'h3)));
      p_pba_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pba_hit |-> (mem_addr >= (pba_reg & ~32'h3)));
    end else begin : g_off
      assign tbl_hit = 1'b0;
      assign pba_hit = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/cfg_space_resp.sv
module cfg_space_resp
  import cfg_space_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          CFG_BYTES   = 4096,
  parameter int          DEV_BASE    = 64,
  parameter logic [31:0] ID_WORD     = 32'h1AB4_5E01,
  parameter int          PM_BASE     = 'h40,
  parameter int          MSI_BASE    = 'h48,
  parameter int          MSIX_BASE   = 'h60,
  parameter logic [15:0] PM_CAPS     = 16'h0003,
  parameter logic [10:0] MX_TSIZE    = 11'd69,
  parameter logic [31:0] MX_TBL_INIT = 32'h0000_2000,
  parameter logic [31:0] MX_PBA_INIT = 32'h0000_3000,
  parameter int          TBL_VEC_B   = 16,
  parameter int          PBA_PER     = 64,
  parameter int          PBA_ENT_B   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       mem_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              tbl_hit,
  output logic              pba_hit
);

  localparam int  OFF_W   = $clog2(CFG_BYTES);
  localparam int  HDR_DW  = DEV_BASE / 4;
  localparam int  HIDX_W  = $clog2(HDR_DW);
  localparam int  PTR_DW  = 'h34 / 4;
  localparam bit  MX_ON   = (MSIX_BASE != 0);
  localparam int  MSI_NXT = MX_ON ? MSIX_BASE : 0;

  // decoder outputs
  logic             legal, in_dev;
  logic [OFF_W-1:0] dw_off;
  logic [4:0]       lane_sh;
  logic [31:0]      narrow_mask, lane_mask;

  cfg_access_dec #(.ADDR_W(ADDR_W), .CFG_BYTES(CFG_BYTES), .DEV_BASE(DEV_BASE)) u_dec (
    .addr(req_addr), .size(req_size), .legal(legal), .in_dev(in_dev), .dw_off(dw_off),
    .lane_sh(lane_sh), .narrow_mask(narrow_mask), .lane_mask(lane_mask)
  );

  // register file
  logic [31:0] hdr_q [HDR_DW];
  logic [15:0] pmcs_q;
  logic [15:0] msi_ctrl_q;
  logic [31:0] msi_addr_q;
  logic [31:0] msi_uaddr_q;
  logic [15:0] msi_data_q;
  logic [1:0]  mx_ctrl_q;
  logic [31:0] mx_tbl_q;
  logic [31:0] mx_pba_q;

  logic [HIDX_W-1:0] hdr_idx;
  logic [31:0]       rd_word;
  logic              cap_hit;
  logic [31:0]       wr_new;
  logic              wr_go;
  int                off;

  assign hdr_idx = dw_off[HIDX_W+1:2];
  assign off     = int'(dw_off);
  assign wr_go   = req_valid && req_write && legal;

  // addressed dword, also the base for byte-merged writes
  always_comb begin
    rd_word = 32'h0;
    cap_hit = 1'b0;
    if (!in_dev) begin
      if (hdr_idx == '0)                        rd_word = ID_WORD;
      else if (int'(hdr_idx) == PTR_DW)         rd_word = {24'h0, 8'(PM_BASE)};
      else                                      rd_word = hdr_q[hdr_idx];
    end else if (off == PM_BASE) begin
      rd_word = {PM_CAPS, cap_hdr(CAPID_PM, 8'(MSI_BASE))};  cap_hit = 1'b1;
    end else if (off == PM_BASE + 4) begin
      rd_word = {16'h0, pmcs_q};                             cap_hit = 1'b1;
    end else if (off == MSI_BASE) begin
      rd_word = {msi_ctrl_q, cap_hdr(CAPID_MSI, 8'(MSI_NXT))}; cap_hit = 1'b1;
    end else if (off == MSI_BASE + 4) begin
      rd_word = msi_addr_q;                                  cap_hit = 1'b1;
    end else if (off == MSI_BASE + 8) begin
      rd_word = msi_uaddr_q;                                 cap_hit = 1'b1;
    end else if (off == MSI_BASE + 12) begin
      rd_word = {16'h0, msi_data_q};                         cap_hit = 1'b1;
    end else if (MX_ON && off == MSIX_BASE) begin
      rd_word = {mx_ctrl_q, 3'b000, MX_TSIZE, cap_hdr(CAPID_MSIX, 8'h00)}; cap_hit = 1'b1;
    end else if (MX_ON && off == MSIX_BASE + 4) begin
      rd_word = mx_tbl_q;                                    cap_hit = 1'b1;
    end else if (MX_ON && off == MSIX_BASE + 8) begin
      rd_word = mx_pba_q;                                    cap_hit = 1'b1;
    end
    wr_new = (rd_word & ~lane_mask) | ((req_wdata << lane_sh) & lane_mask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_DW; i++) hdr_q[i] <= 32'h0;
      pmcs_q      <= 16'h0;
      msi_ctrl_q  <= 16'h0;
      msi_addr_q  <= 32'h0;
      msi_uaddr_q <= 32'h0;
      msi_data_q  <= 16'h0;
      mx_ctrl_q   <= 2'b00;
      mx_tbl_q    <= MX_TBL_INIT;
      mx_pba_q    <= MX_PBA_INIT;
    end else if (wr_go) begin
      if (!in_dev) begin
        for (int i = 1; i < HDR_DW; i++)
          if (i != PTR_DW && int'(hdr_idx) == i) hdr_q[i] <= wr_new;
      end else if (off == PM_BASE + 4)       pmcs_q      <= wr_new[15:0];
      else if (off == MSI_BASE)              msi_ctrl_q  <= wr_new[31:16];
      else if (off == MSI_BASE + 4)          msi_addr_q  <= {wr_new[31:2], 2'b00};
      else if (off == MSI_BASE + 8)          msi_uaddr_q <= wr_new;
      else if (off == MSI_BASE + 12)         msi_data_q  <= wr_new[15:0];
      else if (MX_ON && off == MSIX_BASE)    mx_ctrl_q   <= wr_new[31:30];
      else if (MX_ON && off == MSIX_BASE + 4) mx_tbl_q   <= wr_new;
      else if (MX_ON && off == MSIX_BASE + 8) mx_pba_q   <= wr_new;
    end
  end

  // response stage
  logic        rsp_valid_q, rsp_err_q, rsp_unimpl_q;
  logic [31:0] rsp_rdata_q;
  logic [2:0]  rsp_size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_err_q    <= 1'b0;
      rsp_unimpl_q <= 1'b0;
      rsp_rdata_q  <= 32'h0;
      rsp_size_q   <= 3'd0;
    end else begin
      rsp_valid_q  <= req_valid;
      rsp_err_q    <= req_valid && !legal;
      rsp_unimpl_q <= req_valid && legal && in_dev && !cap_hit;
      rsp_size_q   <= req_size;
      rsp_rdata_q  <= (req_valid && legal && !req_write) ? ((rd_word >> lane_sh) & narrow_mask)
                                                         : 32'h0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_rdata = rsp_rdata_q;

  cfg_msix_win #(.ENABLE(MX_ON), .VEC_BYTES(TBL_VEC_B), .PBA_PER_ENTRY(PBA_PER),
                 .PBA_ENTRY_B(PBA_ENT_B)) u_win (
    .clk(clk), .rst_n(rst_n), .tbl_size(MX_TSIZE), .tbl_reg(mx_tbl_q), .pba_reg(mx_pba_q),
    .mem_addr(mem_addr), .tbl_hit(tbl_hit), .pba_hit(pba_hit)
  );

  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
  p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (pmcs_q == $past(pmcs_q) && mx_tbl_q == $past(mx_tbl_q)
                 && msi_addr_q == $past(msi_addr_q) && msi_data_q == $past(msi_data_q)));
  p_byte_read_narrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_size_q == 3'd1) |-> (rsp_rdata[31:8] == 24'h0));
  p_unimpl_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_unimpl_q |-> (rsp_rdata == 32'h0 && !rsp_err));

endmodule

// File: tb/cfg_space_resp_tb.sv
module cfg_space_resp_tb;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 47;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h000, 3'd4, 32'h0,        32'h1AB45E01, 1'b0, 8'd1},  // R1 identity
    '{1'b0, 16'h001, 3'd1, 32'h0,        32'h0000005E, 1'b0, 8'd3},  // R3
    '{1'b0, 16'h002, 3'd2, 32'h0,        32'h00001AB4, 1'b0, 8'd3},  // R3
    '{1'b0, 16'h003, 3'd1, 32'h0,        32'h0000001A, 1'b0, 8'd3},  // R3
    '{1'b0, 16'h034, 3'd1, 32'h0,        32'h00000040, 1'b0, 8'd2},  // R2 pointer
    '{1'b0, 16'h040, 3'd4, 32'h0,        32'h00034801, 1'b0, 8'd2},  // R2 PM header
    '{1'b0, 16'h048, 3'd4, 32'h0,        32'h00006005, 1'b0, 8'd2},  // R2 MSI header
    '{1'b0, 16'h060, 3'd4, 32'h0,        32'h00450011, 1'b0, 8'd2},  // R2 MSI-X header
    '{1'b0, 16'h064, 3'd4, 32'h0,        32'h00002000, 1'b0, 8'd1},  // R1
    '{1'b0, 16'h068, 3'd4, 32'h0,        32'h00003000, 1'b0, 8'd1},  // R1
    '{1'b1, 16'h000, 3'd4, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd4},  // R4 RO identity
    '{1'b0, 16'h000, 3'd4, 32'h0,        32'h1AB45E01, 1'b0, 8'd4},
    '{1'b1, 16'h062, 3'd2, 32'h0000FFFF, 32'h0,        1'b0, 8'd4},  // R4 control bits
    '{1'b0, 16'h060, 3'd4, 32'h0,        32'hC0450011, 1'b0, 8'd4},
    '{1'b1, 16'h061, 3'd1, 32'h000000FF, 32'h0,        1'b0, 8'd4},  // R4 next byte RO
    '{1'b0, 16'h060, 3'd4, 32'h0,        32'hC0450011, 1'b0, 8'd4},
    '{1'b1, 16'h04C, 3'd4, 32'h12345677, 32'h0,        1'b0, 8'd12}, // R12
    '{1'b0, 16'h04C, 3'd4, 32'h0,        32'h12345674, 1'b0, 8'd12},
    '{1'b1, 16'h04D, 3'd1, 32'h000000AB, 32'h0,        1'b0, 8'd4},  // R4 single byte
    '{1'b0, 16'h04C, 3'd4, 32'h0,        32'h1234AB74, 1'b0, 8'd4},
    '{1'b1, 16'h044, 3'd2, 32'h0000BEEF, 32'h0,        1'b0, 8'd4},
    '{1'b0, 16'h044, 3'd4, 32'h0,        32'h0000BEEF, 1'b0, 8'd4},
    '{1'b0, 16'h045, 3'd1, 32'h0,        32'h000000BE, 1'b0, 8'd3},
    '{1'b0, 16'h06C, 3'd4, 32'h0,        32'h0,        1'b0, 8'd5},  // R5
    '{1'b0, 16'h100, 3'd2, 32'h0,        32'h0,        1'b0, 8'd5},
    '{1'b0, 16'hFFC, 3'd4, 32'h0,        32'h0,        1'b0, 8'd5},
    '{1'b1, 16'h080, 3'd4, 32'hFFFFFFFF, 32'h0,        1'b0, 8'd6},  // R6
    '{1'b0, 16'h080, 3'd4, 32'h0,        32'h0,        1'b0, 8'd6},
    '{1'b1, 16'h034, 3'd1, 32'h00000099, 32'h0,        1'b0, 8'd4},  // R4 pointer RO
    '{1'b0, 16'h034, 3'd1, 32'h0,        32'h00000040, 1'b0, 8'd4},
    '{1'b1, 16'h010, 3'd4, 32'hCAFEF00D, 32'h0,        1'b0, 8'd4},
    '{1'b0, 16'h012, 3'd2, 32'h0,        32'h0000CAFE, 1'b0, 8'd3},
    '{1'b0, 16'h000, 3'd3, 32'h0,        32'h0,        1'b1, 8'd7},  // R7 size 3
    '{1'b0, 16'h000, 3'd0, 32'h0,        32'h0,        1'b1, 8'd7},
    '{1'b0, 16'h1000, 3'd4, 32'h0,       32'h0,        1'b1, 8'd7},
    '{1'b0, 16'h002, 3'd4, 32'h0,        32'h0,        1'b1, 8'd7},
    '{1'b0, 16'h001, 3'd2, 32'h0,        32'h0,        1'b1, 8'd7},
    '{1'b1, 16'h1010, 3'd4, 32'h11111111, 32'h0,       1'b1, 8'd7},
    '{1'b1, 16'h011, 3'd2, 32'h00002222, 32'h0,        1'b1, 8'd7},
    '{1'b0, 16'h010, 3'd4, 32'h0,        32'hCAFEF00D, 1'b0, 8'd7},
    '{1'b1, 16'h064, 3'd4, 32'h00005003, 32'h0,        1'b0, 8'd9},  // R9
    '{1'b0, 16'h064, 3'd4, 32'h0,        32'h00005003, 1'b0, 8'd9},
    '{1'b1, 16'h068, 3'd4, 32'h00003006, 32'h0,        1'b0, 8'd10}, // R10
    '{1'b0, 16'h068, 3'd4, 32'h0,        32'h00003006, 1'b0, 8'd10},
    '{1'b0, 16'h054, 3'd4, 32'h0,        32'h0,        1'b0, 8'd1},
    '{1'b1, 16'h054, 3'd4, 32'hFFFF1234, 32'h0,        1'b0, 8'd4},
    '{1'b0, 16'h054, 3'd4, 32'h0,        32'h00001234, 1'b0, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [2:0]  req_size = 3'd4;
  logic [31:0] req_wdata = '0, mem_addr = '0;
  logic        rsp_valid, rsp_err, tbl_hit, pba_hit;
  logic [31:0] rsp_rdata;
  logic        o_valid, o_err, o_tbl, o_pba;
  logic [31:0] o_rdata;
  int          errors = 0, checks = 0;

  always #5 clk = ~clk;

  cfg_space_resp u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .tbl_hit(tbl_hit), .pba_hit(pba_hit));

  cfg_space_resp #(.MSIX_BASE(0)) u_off (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata), .mem_addr(mem_addr),
    .rsp_valid(o_valid), .rsp_err(o_err), .rsp_rdata(o_rdata),
    .tbl_hit(o_tbl), .pba_hit(o_pba));

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle request; response sampled at the following falling edge
  task automatic xfer(input logic w, input logic [15:0] a, input logic [2:0] s,
                      input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic hit_chk(input logic [31:0] a, input logic et, input logic ep, input string tag);
    mem_addr = a;
    #1;
    check(tbl_hit == et && pba_hit == ep, tag, {30'h0, tbl_hit, pba_hit}, {30'h0, et, ep});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs idle while in reset
    check(!rsp_valid && !rsp_err && rsp_rdata == 0, "R1 reset outputs", rsp_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      check(rsp_valid, $sformatf("R8 vec %0d valid", i), {31'h0, rsp_valid}, 32'h1);
      check(rsp_err == VECS[i].err, $sformatf("R%0d vec %0d err", VECS[i].req, i),
            {31'h0, rsp_err}, {31'h0, VECS[i].err});
      check(rsp_rdata == VECS[i].exp, $sformatf("R%0d vec %0d data", VECS[i].req, i),
            rsp_rdata, VECS[i].exp);
    end

    // R8 and R7: no response and no error in the idle cycle after a request
    xfer(1'b0, 16'h000, 3'd3, 32'h0);
    check(rsp_err, "R7 error raised", {31'h0, rsp_err}, 32'h1);
    @(negedge clk);
    check(!rsp_valid, "R8 idle cycle", {31'h0, rsp_valid}, 32'h0);
    check(!rsp_err, "R7 single-cycle error", {31'h0, rsp_err}, 32'h0);

    // R9: table base 0x5000, 70 vectors * 16 bytes -> end 0x5460
    hit_chk(32'h00004FFF, 1'b0, 1'b0, "R9 below table");
    hit_chk(32'h00005000, 1'b1, 1'b0, "R9 table first");
    hit_chk(32'h0000545F, 1'b1, 1'b0, "R9 table last");
    hit_chk(32'h00005460, 1'b0, 1'b0, "R9 table end");
    // R10: PBA base 0x3004, ceil(70/64)=2 entries * 8 -> end 0x3014
    hit_chk(32'h00003003, 1'b0, 1'b0, "R10 below pba");
    hit_chk(32'h00003004, 1'b0, 1'b1, "R10 pba first");
    hit_chk(32'h00003013, 1'b0, 1'b1, "R10 pba last rounded");
    hit_chk(32'h00003014, 1'b0, 1'b0, "R10 pba end");

    // R11: instance without MSI-X
    mem_addr = 32'h00002000; #1;
    check(!o_tbl && !o_pba, "R11 no table hit", {30'h0, o_tbl, o_pba}, 32'h0);
    mem_addr = 32'h00003000; #1;
    check(!o_tbl && !o_pba, "R11 no pba hit", {30'h0, o_tbl, o_pba}, 32'h0);
    @(negedge clk);
    xfer(1'b0, 16'h060, 3'd4, 32'h0);
    check(o_rdata == 32'h0 && !o_err, "R11 capability absent", o_rdata, 32'h0);
    xfer(1'b0, 16'h048, 3'd4, 32'h0);
    check(o_rdata == 32'h00000005, "R11 MSI next is zero", o_rdata, 32'h00000005);

    // R1: second reset restores defaults and windows
    rst_n = 1'b0;
    @(negedge clk);
    check(!rsp_valid && !rsp_err, "R1 reset mid-run", {30'h0, rsp_valid, rsp_err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    xfer(1'b0, 16'h064, 3'd4, 32'h0);
    check(rsp_rdata == 32'h00002000, "R1 table offset default", rsp_rdata, 32'h00002000);
    xfer(1'b0, 16'h044, 3'd4, 32'h0);
    check(rsp_rdata == 32'h0, "R1 PM control default", rsp_rdata, 32'h0);
    hit_chk(32'h0000245F, 1'b1, 1'b0, "R9 default table last");
    hit_chk(32'h00002460, 1'b0, 1'b0, "R9 default table end");
    hit_chk(32'h0000300F, 1'b0, 1'b1, "R10 default pba last");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule